// File: doc/BRIEF.md
# Radix-2 FFT Address Sequencer

This block steps an in-place radix-2 decimation-in-time transform of 32 complex points through its 5 levels of 16 butterflies. On every active clock it gives the pair of data-memory read addresses for one butterfly and the address of the twiddle factor that goes with it. It also gives a write strobe and write addresses that trail the reads by the fixed latency of the arithmetic pipeline that lies outside the block. The butterfly index counts in plain binary. Each read address is that index doubled, with 0 or 1 added, and then rotated left by the level number inside a 5-bit word. The twiddle address is the index ANDed with a mask that gains one more set bit from the top at each level.

The controller is a four-state machine. IDLE waits for a start pulse; the transition IDLE→CLEAR is taken when `start` is high. CLEAR holds every counter at zero for two clocks and then takes CLEAR→RUN. RUN issues one butterfly per clock; when the butterfly index reaches 15 it takes RUN→DRAIN. DRAIN keeps the butterfly counter at zero for `HOLD_LEN` clocks so that results still in flight can be written. It then takes DRAIN→RUN to the next level, or DRAIN→IDLE after level 4. A bank-select output changes once after each level's last write, so the ping-pong memories swap roles. A done flag rises after the final write of the transform.

Top module: `fft_addr_seq`

## Requirements
- R1: While reset is active, and after it is released until a start is accepted, every output is 0: both read addresses, the twiddle address, `rd_valid`, `wr_en`, both write addresses, `bank_sel` and `done`.
- R2: A high `start` is accepted only in IDLE. The first `rd_valid` of the transform becomes visible after the third rising edge that follows the accepting edge, because of two clear-hold cycles and one output register. A `start` that is seen while a transform runs has no effect.
- R3: For level i (0..4, in ascending order) and butterfly j (0..15, in ascending order), `rd_addr_a` equals 2j and `rd_addr_b` equals 2j+1, each rotated left by i positions as a 5-bit circular value.
- R4: `tw_addr` equals j AND the level mask. The mask is 0000, 1000, 1100, 1110 and 1111 for levels 0 to 4, with bit 3 as the MSB.
- R5: Each level gives exactly 16 consecutive `rd_valid` cycles. Between two levels, `rd_valid` is low for exactly `HOLD_LEN` cycles (default 5).
- R6: `rd_addr_a`, `rd_addr_b` and `tw_addr` are 0 in every cycle in which `rd_valid` is low.
- R7: `wr_en`, `wr_addr_a` and `wr_addr_b` equal `rd_valid`, `rd_addr_a` and `rd_addr_b` from exactly `PIPE_LAT` cycles earlier (default 5). So there are 16 writes per level, and the last write of a level comes before the first read of the next level.
- R8: `bank_sel` is cleared to 0 by an accepted start. It inverts on the edge that follows the last write of each level, so it ends a transform at 1.
- R9: `done` is 0 from the accepting edge on. It becomes 1 on the edge after the last write of level 4 and stays 1 until the next accepted start.
- R10: If a start is accepted on the same edge that would raise `done`, the start wins: `done` stays 0 and the new transform runs with normal timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a transform |
| rd_valid | output | 1 | Read addresses below are valid this cycle |
| rd_addr_a | output | 5 | Sum-wing data read address |
| rd_addr_b | output | 5 | Difference-wing data read address |
| tw_addr | output | 4 | Twiddle ROM address |
| wr_en | output | 1 | Write strobe, delayed by PIPE_LAT |
| wr_addr_a | output | 5 | Sum-wing write address |
| wr_addr_b | output | 5 | Difference-wing write address |
| bank_sel | output | 1 | Ping-pong bank select |
| done | output | 1 | Transform finished |

## Verification
The delicate coincidence is a new start that arrives on the edge where the final write of level 4 would set `done`. With the defaults (`HOLD_LEN` equal to `PIPE_LAT`), the machine reaches IDLE exactly one edge before that write retires. The bench therefore holds `start` high across several transforms, so each new transform is accepted at the first idle edge. The bench checks that `done` stays low, that `bank_sel` restarts at 0, and that the new address stream keeps its normal timing. A behavioural model built from level/index arithmetic and a queue for the write delay is compared with all outputs on every clock. The model also covers start pulses given in mid-run, which must be ignored.

// File: rtl/fft_seq_pkg.sv
package fft_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_CLEAR,
        SEQ_RUN,
        SEQ_DRAIN
    } seq_state_t;

    typedef struct packed {
        logic vld;
        logic lst;
        logic fin;
    } seq_tag_t;

endpackage

// File: rtl/fft_seq_ctrl.sv
module fft_seq_ctrl
    import fft_seq_pkg::*;
#(
    parameter int BFLY_W   = 4,
    parameter int LVL_W    = 3,
    parameter int NUM_LVL  = 5,
    parameter int HOLD_LEN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  seq_tag_t          wr_tag,
    output seq_tag_t          rd_tag,
    output logic [BFLY_W-1:0] bfly,
    output logic [LVL_W-1:0]  level,
    output logic [BFLY_W-1:0] mask,
    output logic              bank_sel,
    output logic              done
);

    localparam int HOLD_W = $clog2(HOLD_LEN + 1);

    seq_state_t        state, nxt;
    logic              clr_cnt;
    logic [HOLD_W-1:0] hold_cnt;
    logic              accept, clr_hold, lvl_end, last_lvl, bfly_end;

    assign accept   = (state == SEQ_IDLE) && start;
    assign clr_hold = accept || (state == SEQ_CLEAR);
    assign bfly_end = (bfly == {BFLY_W{1'b1}});
    assign last_lvl = (level == LVL_W'(NUM_LVL - 1));
    assign lvl_end  = (state == SEQ_DRAIN) && (hold_cnt == HOLD_W'(HOLD_LEN - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            SEQ_IDLE:  if (start)    nxt = SEQ_CLEAR;
            SEQ_CLEAR: if (clr_cnt)  nxt = SEQ_RUN;
            SEQ_RUN:   if (bfly_end) nxt = SEQ_DRAIN;
            SEQ_DRAIN: if (lvl_end)  nxt = last_lvl ? SEQ_IDLE : SEQ_RUN;
            default:                 nxt = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_cnt  <= 1'b0;
            hold_cnt <= '0;
            bfly     <= '0;
            level    <= '0;
            mask     <= '0;
        end else begin
            clr_cnt  <= (state == SEQ_CLEAR) ? ~clr_cnt : 1'b0;
            hold_cnt <= (state == SEQ_DRAIN && !lvl_end) ? hold_cnt + 1'b1 : '0;
            bfly     <= (state == SEQ_RUN) ? bfly + 1'b1 : '0;
            if (clr_hold) begin
                level <= '0;
                mask  <= '0;
            end else if (lvl_end) begin
                level <= last_lvl ? '0 : level + 1'b1;
                mask  <= last_lvl ? '0 : {1'b1, mask[BFLY_W-1:1]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_sel <= 1'b0;
            done     <= 1'b0;
        end else if (clr_hold) begin
            bank_sel <= 1'b0;
            done     <= 1'b0;
        end else if (wr_tag.vld && wr_tag.lst) begin
            bank_sel <= ~bank_sel;
            if (wr_tag.fin) done <= 1'b1;
        end
    end

    always_comb begin
        rd_tag.vld = (state == SEQ_RUN);
        rd_tag.lst = rd_tag.vld && bfly_end;
        rd_tag.fin = rd_tag.lst && last_lvl;
    end

endmodule

// File: rtl/fft_seq_addr.sv
module fft_seq_addr
    import fft_seq_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int LVL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_tag_t          tag_in,
    input  logic [ADDR_W-2:0] bfly,
    input  logic [LVL_W-1:0]  level,
    input  logic [ADDR_W-2:0] mask,
    output seq_tag_t          tag_out,
    output logic [ADDR_W-1:0] addr_a,
    output logic [ADDR_W-1:0] addr_b,
    output logic [ADDR_W-2:0] tw
);

    logic [ADDR_W-1:0]   even_ix, odd_ix;
    logic [2*ADDR_W-1:0] even_rot, odd_rot;

    assign even_ix  = {bfly, 1'b0};
    assign odd_ix   = {bfly, 1'b1};
    assign even_rot = {even_ix, even_ix} << level;
    assign odd_rot  = {odd_ix, odd_ix} << level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_out <= '0;
            addr_a  <= '0;
            addr_b  <= '0;
            tw      <= '0;
        end else if (tag_in.vld) begin
            tag_out <= tag_in;
            addr_a  <= even_rot[2*ADDR_W-1:ADDR_W];
            addr_b  <= odd_rot[2*ADDR_W-1:ADDR_W];
            tw      <= bfly & mask;
        end else begin
            tag_out <= '0;
            addr_a  <= '0;
            addr_b  <= '0;
            tw      <= '0;
        end
    end

endmodule

// File: rtl/fft_seq_delay.sv
module fft_seq_delay #(
    parameter int WIDTH = 13,
    parameter int DEPTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stg [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= din;
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign dout = stg[DEPTH-1];

endmodule

// File: rtl/fft_addr_seq.sv
module fft_addr_seq
    import fft_seq_pkg::*;
#(
    parameter int LOG2N    = 5,
    parameter int PIPE_LAT = 5,
    parameter int HOLD_LEN = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             rd_valid,
    output logic [LOG2N-1:0] rd_addr_a,
    output logic [LOG2N-1:0] rd_addr_b,
    output logic [LOG2N-2:0] tw_addr,
    output logic             wr_en,
    output logic [LOG2N-1:0] wr_addr_a,
    output logic [LOG2N-1:0] wr_addr_b,
    output logic             bank_sel,
    output logic             done
);

    localparam int ADDR_W = LOG2N;
    localparam int BFLY_W = LOG2N - 1;
    localparam int LVL_W  = $clog2(LOG2N);
    localparam int TAG_W  = $bits(seq_tag_t);
    localparam int DW     = TAG_W + 2 * ADDR_W;

    seq_tag_t          cur_tag, rd_tag, wr_tag;
    logic [BFLY_W-1:0] bfly, mask;
    logic [LVL_W-1:0]  level;
    logic [DW-1:0]     dly_in, dly_out;

    fft_seq_ctrl #(
        .BFLY_W  (BFLY_W),
        .LVL_W   (LVL_W),
        .NUM_LVL (LOG2N),
        .HOLD_LEN(HOLD_LEN)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .wr_tag  (wr_tag),
        .rd_tag  (cur_tag),
        .bfly    (bfly),
        .level   (level),
        .mask    (mask),
        .bank_sel(bank_sel),
        .done    (done)
    );

    fft_seq_addr #(
        .ADDR_W(ADDR_W),
        .LVL_W (LVL_W)
    ) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .tag_in (cur_tag),
        .bfly   (bfly),
        .level  (level),
        .mask   (mask),
        .tag_out(rd_tag),
        .addr_a (rd_addr_a),
        .addr_b (rd_addr_b),
        .tw     (tw_addr)
    );

    assign dly_in = {rd_tag, rd_addr_a, rd_addr_b};

    fft_seq_delay #(
        .WIDTH(DW),
        .DEPTH(PIPE_LAT)
    ) u_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (dly_in),
        .dout (dly_out)
    );

    assign wr_tag    = dly_out[DW-1 -: TAG_W];
    assign wr_addr_a = dly_out[2*ADDR_W-1 -: ADDR_W];
    assign wr_addr_b = dly_out[ADDR_W-1:0];
    assign wr_en     = wr_tag.vld;
    assign rd_valid  = rd_tag.vld;

endmodule

// File: rtl/fft_addr_seq_chk.sv
module fft_addr_seq_chk #(
    parameter int LOG2N = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             rd_valid,
    input logic [LOG2N-1:0] rd_addr_a,
    input logic [LOG2N-1:0] rd_addr_b,
    input logic [LOG2N-2:0] tw_addr,
    input logic             wr_en,
    input logic [LOG2N-1:0] wr_addr_a,
    input logic [LOG2N-1:0] wr_addr_b,
    input logic             bank_sel,
    input logic             done
);

    // R6
    rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_addr_a == '0 && rd_addr_b == '0 && tw_addr == '0));

    // R3
    rd_pair_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $countones(rd_addr_a ^ rd_addr_b) == 1);

    // R7
    wr_pair_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $countones(wr_addr_a ^ wr_addr_b) == 1);

    // R9
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(wr_en));

    // R8
    bank_move_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bank_sel) |-> ($past(wr_en) || $past(start)));

    // R9
    no_done_while_reading_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !done);

endmodule

bind fft_addr_seq fft_addr_seq_chk #(.LOG2N(LOG2N)) u_chk (.*);

// File: tb/sim_fft_addr_seq.sv
module sim_fft_addr_seq;

    localparam int P     = 5;
    localparam int H     = 5;
    localparam int LVLS  = 5;
    localparam int NB    = 16;
    localparam int SPAN  = NB + H;
    localparam int TOT   = 2 + LVLS * SPAN;

    typedef struct packed {
        logic       v;
        logic       lst;
        logic       fin;
        logic [4:0] a;
        logic [4:0] b;
        logic [3:0] tw;
    } ev_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       rd_valid, wr_en, bank_sel, done;
    logic [4:0] rd_addr_a, rd_addr_b, wr_addr_a, wr_addr_b;
    logic [3:0] tw_addr;

    int  checks = 0;
    int  fails = 0;
    bit  finished = 1'b0;

    ev_t q[$];
    ev_t exp_rd, exp_wr;
    bit  m_busy, exp_bank, exp_done, coin_pend;
    int  m_t, coin_seen;

    always #10 clk = ~clk;

    fft_addr_seq #(.LOG2N(5), .PIPE_LAT(P), .HOLD_LEN(H)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .rd_valid(rd_valid), .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
        .tw_addr(tw_addr), .wr_en(wr_en), .wr_addr_a(wr_addr_a),
        .wr_addr_b(wr_addr_b), .bank_sel(bank_sel), .done(done)
    );

    function automatic int rotl5(int v, int s);
        return ((v << s) | (v >> (5 - s))) & 31;
    endfunction

    function automatic ev_t rd_at(bit busy, int t);
        ev_t e;
        int  u, lvl, j;
        e = '0;
        u = t - 3;
        if (!busy || u < 0 || u >= LVLS * SPAN || (u % SPAN) >= NB) return e;
        lvl   = u / SPAN;
        j     = u % SPAN;
        e.v   = 1'b1;
        e.a   = 5'(rotl5(2 * j, lvl));
        e.b   = 5'(rotl5(2 * j + 1, lvl));
        e.tw  = 4'(j & ((15 << (4 - lvl)) & 15));
        e.lst = (j == NB - 1);
        e.fin = (j == NB - 1) && (lvl == LVLS - 1);
        return e;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model, advanced on every rising edge
    always @(posedge clk) begin
        bit preidle, acc, inclr;
        if (!rst_n) begin
            q = {};
            for (int k = 0; k < P; k++) q.push_back('0);
            exp_rd = '0; exp_wr = '0;
            m_busy = 0; m_t = 0; exp_bank = 0; exp_done = 0; coin_pend = 0;
        end else begin
            preidle = !m_busy || (m_t >= TOT);
            acc     = start && preidle;
            inclr   = m_busy && (m_t < 2);
            if (acc && exp_wr.v && exp_wr.fin) begin
                coin_pend = 1;
                coin_seen++;
            end
            if (acc || inclr) begin
                exp_bank = 0;
                exp_done = 0;
            end else if (exp_wr.v && exp_wr.lst) begin
                exp_bank = ~exp_bank;
                if (exp_wr.fin) exp_done = 1;
            end
            if (acc) begin
                m_busy = 1;
                m_t = 0;
            end else if (m_busy) begin
                m_t++;
            end
            exp_rd = rd_at(m_busy, m_t);
            q.push_back(exp_rd);
            exp_wr = q.pop_front();
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R2 R5 rd_valid", rd_valid, exp_rd.v);
            chk("R3 rd_addr_a", rd_addr_a, exp_rd.a);
            chk("R3 rd_addr_b", rd_addr_b, exp_rd.b);
            chk("R4 R6 tw_addr", tw_addr, exp_rd.tw);
            chk("R7 wr_en", wr_en, exp_wr.v);
            chk("R7 wr_addr_a", wr_addr_a, exp_wr.a);
            chk("R7 wr_addr_b", wr_addr_b, exp_wr.b);
            chk("R8 bank_sel", bank_sel, exp_bank);
            chk("R9 done", done, exp_done);
            if (coin_pend) begin
                chk("R10 done held low on coinciding start", done, 0);
                coin_pend = 0;
            end
        end
    end

    task automatic wait_done();
        for (int k = 0; k < 400 && !done; k++) @(negedge clk);
    endtask

    initial begin
        coin_seen = 0;
        repeat (3) @(negedge clk);
        chk("R1 rd_valid in reset", rd_valid, 0);
        chk("R1 wr_en in reset", wr_en, 0);
        chk("R1 done in reset", done, 0);
        chk("R1 bank_sel in reset", bank_sel, 0);
        chk("R1 addresses in reset", rd_addr_a | rd_addr_b | tw_addr | wr_addr_a | wr_addr_b, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        start = 1'b1;             // ignored: transform running (R2)
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk("R9 done raised after first transform", done, 1);
        chk("R8 bank_sel after five levels", bank_sel, 1);
        repeat (6) @(negedge clk);
        start = 1'b1;             // held: back-to-back runs hit the R10 coincidence
        repeat (2 * TOT + 30) @(negedge clk);
        start = 1'b0;
        wait_done();
        repeat (8) @(negedge clk);
        chk("R10 coincidence exercised", (coin_seen > 0) ? 1 : 0, 1);
        chk("R9 done at end", done, 1);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog R9 act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule